// File: doc/BRIEF.md
# Parity-Protected Control Register File

This block is a compact bank of software-owned control registers. A CPU-side port carries an address, write data, a write enable and a read data return. Behind it sit one standalone register and a bank of eight identical registers. Each register holds three fields, and each field stores one extra bit: the even parity of its data, captured on the same clock edge as the data.

The stored parity of every field is compared with the field contents on every cycle. If any comparison fails in any register, the mismatch is registered onto a single `parity_error` output. This flags an upset in the stored state, such as a single flipped bit, within two cycles. Software clears the flag by rewriting the affected register, which recomputes the parity. A write to any other register leaves the flag set.

Top module: `parity_csr`

## Requirements
- R1: While reset is held (synchronous, active-high), every field and parity bit is cleared. After release, every register reads 0 and `parity_error` is 0.
- R2: Each 32-bit register packs a 16-bit field in bits [15:0], an 8-bit field in bits [23:16] and a 1-bit field in bit [24]. Bits [31:25] always read 0.
- R3: The standalone register decodes at byte address 0x0000. Bank entry i (0..7) decodes at 0x1000 + 4*i. Every other address reads 0, and a write to it changes no register.
- R4: A write with `wr_en` high stores `wdata[24:0]` into the addressed register at the clock edge. Reads are combinational from `addr`.
- R5: Software writes of arbitrary data to any register never raise `parity_error`.
- R6: If one stored data bit of any field differs from the value written, `parity_error` is 1 within two clock edges. It stays 1 while the corruption remains.
- R7: A write to a register other than the corrupted one does not clear `parity_error`.
- R8: A write to the register holding the corrupted field recomputes its parity. `parity_error` is 0 by the second clock edge after that write.
- R9: `parity_error` is never X or Z after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Byte address for read and write |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write enable for the addressed register |
| rd_data | output | 32 | Combinational read data for `addr` |
| parity_error | output | 1 | Registered OR of all field parity mismatches |

## Verification
The bench writes random data to random registers, including unmapped addresses, and checks after each write that `parity_error` stays low and that read-back matches a bench model. These checks separate a correct parity capture from one that is missing or stale. It then corrupts single stored bits, one per field width, in the standalone register and in the bank entries. The flag must rise and must survive a write to an unrelated register, which shows the parity is tracked per register rather than cleared by any write. A rewrite of the corrupted register must then clear it.

// File: rtl/parity_csr.sv
module parity_csr #(
  parameter int ADDR_W   = 16,
  parameter int ARR_N    = 8,
  parameter int ARR_BASE = 'h1000,
  parameter int STRIDE   = 4,
  parameter int W_A      = 16,
  parameter int W_B      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  output logic [31:0]       rd_data,
  output logic              parity_error
);
  localparam int NREG = ARR_N + 1;
  localparam int LO_B = W_A;
  localparam int LO_C = W_A + W_B;

  logic [NREG*W_A-1:0] fa_q;
  logic [NREG*W_B-1:0] fb_q;
  logic [NREG-1:0]     fc_q;
  logic [NREG-1:0]     pa_q, pb_q, pc_q;
  logic [NREG-1:0]     hit, bad;
  logic [NREG*32-1:0]  view;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam int BASE = (k == 0) ? 0 : ARR_BASE + (k - 1) * STRIDE;
    assign hit[k] = (addr == ADDR_W'(BASE));

    always_ff @(posedge clk) begin
      if (rst) begin
        fa_q[k*W_A +: W_A] <= '0;
        fb_q[k*W_B +: W_B] <= '0;
        fc_q[k]            <= 1'b0;
        pa_q[k]            <= 1'b0;
        pb_q[k]            <= 1'b0;
        pc_q[k]            <= 1'b0;
      end else if (wr_en && hit[k]) begin
        fa_q[k*W_A +: W_A] <= wdata[W_A-1:0];
        fb_q[k*W_B +: W_B] <= wdata[LO_C-1:LO_B];
        fc_q[k]            <= wdata[LO_C];
        pa_q[k]            <= ^wdata[W_A-1:0];
        pb_q[k]            <= ^wdata[LO_C-1:LO_B];
        pc_q[k]            <= wdata[LO_C];
      end
    end

    assign bad[k] = (^fa_q[k*W_A +: W_A] != pa_q[k]) |
                    (^fb_q[k*W_B +: W_B] != pb_q[k]) |
                    (fc_q[k] != pc_q[k]);

    assign view[k*32 +: 32] = hit[k]
      ? {{(32-LO_C-1){1'b0}}, fc_q[k], fb_q[k*W_B +: W_B], fa_q[k*W_A +: W_A]}
      : 32'd0;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) rd_data = rd_data | view[k*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) parity_error <= 1'b0;
    else     parity_error <= |bad;
  end
endmodule

// File: rtl/parity_csr_chk.sv
module parity_csr_chk #(
  parameter int ADDR_W   = 16,
  parameter int ARR_N    = 8,
  parameter int ARR_BASE = 'h1000,
  parameter int STRIDE   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              wr_en,
  input logic [31:0]       rd_data,
  input logic              parity_error
);
  logic mapped;
  assign mapped = (addr == '0) ||
                  (int'(addr) >= ARR_BASE && int'(addr) < ARR_BASE + ARR_N * STRIDE &&
                   ((int'(addr) - ARR_BASE) % STRIDE) == 0);

  AST_NO_X_ERR: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(parity_error)); // R9

  AST_CLEAN_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !parity_error); // R1

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:25] == 7'd0); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> rd_data == 32'd0); // R3

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mapped) |=> (addr != $past(addr)) ||
                          (rd_data == {7'd0, $past(wdata[24:0])})); // R4
endmodule

bind parity_csr parity_csr_chk #(
  .ADDR_W(ADDR_W), .ARR_N(ARR_N), .ARR_BASE(ARR_BASE), .STRIDE(STRIDE)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_data(rd_data), .parity_error(parity_error)
);

// File: tb/parity_csr_bench.sv
`timescale 1ns/1ps
module parity_csr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rd_data;
  logic        parity_error;

  int checks = 0;
  int failures = 0;
  logic [24:0] model [9];

  always #5 clk = ~clk;

  parity_csr u_parity_csr (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_data(rd_data), .parity_error(parity_error)
  );

  function automatic logic [15:0] reg_addr(int k);
    return (k == 0) ? 16'h0000 : 16'(16'h1000 + (k - 1) * 4);
  endfunction

  function automatic int reg_index(logic [15:0] a);
    if (a == 16'h0000) return 0;
    for (int i = 0; i < 8; i++) if (a == 16'(16'h1000 + i * 4)) return i + 1;
    return -1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (reg_index(a) >= 0) model[reg_index(a)] = d[24:0];
  endtask

  task automatic do_read(string req, logic [15:0] a);
    int k;
    @(negedge clk);
    addr = a;
    #1;
    k = reg_index(a);
    check(req, rd_data, (k >= 0) ? {7'd0, model[k]} : 32'd0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] odd_addr [5];
    odd_addr[0] = 16'h0004; odd_addr[1] = 16'h1020; odd_addr[2] = 16'h1001;
    odd_addr[3] = 16'h0FFC; odd_addr[4] = 16'h2000;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 9; k++) model[k] = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 error after reset", {31'd0, parity_error}, 32'd0);
    for (int k = 0; k < 9; k++) do_read("R1 reset value", reg_addr(k));

    // R2 field packing: upper bits dropped
    do_write(16'h0000, 32'hFFFF_FFFF);
    do_read("R2 packing all ones", 16'h0000);
    do_write(16'h101C, 32'hABCD_1234);
    do_read("R2 packing pattern", 16'h101C);

    // R3 unmapped addresses
    for (int i = 0; i < 5; i++) begin
      do_write(odd_addr[i], 32'h01FF_FFFF);
      do_read("R3 unmapped read", odd_addr[i]);
    end
    for (int k = 0; k < 9; k++) do_read("R3 no side effect", reg_addr(k));

    // R4 R5 random traffic
    for (int n = 0; n < 300; n++) begin
      int r = int'($urandom % 11);
      logic [15:0] a = (r < 9) ? reg_addr(r) : odd_addr[$urandom % 5];
      do_write(a, $urandom);
      @(negedge clk);
      check("R5 no error on write", {31'd0, parity_error}, 32'd0);
      check("R9 error known", {31'd0, $isunknown(parity_error)}, 32'd0);
      do_read("R4 readback", reg_addr(int'($urandom % 9)));
    end

    // R6 R7 R8 fault in the standalone register, 16-bit field
    do_write(16'h0000, 32'h0);
    @(negedge clk);
    force u_parity_csr.fa_q[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 flip in field A", {31'd0, parity_error}, 32'd1);
    repeat (3) @(negedge clk);
    check("R6 error held", {31'd0, parity_error}, 32'd1);
    do_write(16'h1000, $urandom);
    @(negedge clk);
    check("R7 other write keeps error", {31'd0, parity_error}, 32'd1);
    @(negedge clk);
    release u_parity_csr.fa_q[3];
    do_write(16'h0000, 32'h0000_1234);
    @(negedge clk);
    check("R8 rewrite clears", {31'd0, parity_error}, 32'd0);

    // R6 R8 fault in bank entry 4, 8-bit field
    do_write(16'h1010, 32'h0);
    @(negedge clk);
    force u_parity_csr.fb_q[5*8+2] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 flip in field B", {31'd0, parity_error}, 32'd1);
    do_write(16'h0000, 32'h0);
    @(negedge clk);
    check("R7 other write keeps error B", {31'd0, parity_error}, 32'd1);
    release u_parity_csr.fb_q[5*8+2];
    do_write(16'h1010, 32'h00AA_0000);
    @(negedge clk);
    check("R8 rewrite clears B", {31'd0, parity_error}, 32'd0);

    // R6 R8 fault in last bank entry, 1-bit field
    do_write(16'h101C, 32'h0100_0000);
    @(negedge clk);
    force u_parity_csr.fc_q[8] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 flip in field C", {31'd0, parity_error}, 32'd1);
    release u_parity_csr.fc_q[8];
    do_write(16'h101C, 32'h0100_0001);
    @(negedge clk);
    check("R8 rewrite clears C", {31'd0, parity_error}, 32'd0);
    for (int k = 0; k < 9; k++) do_read("R4 final readback", reg_addr(k));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule